// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter with an overflow flag and an interrupt request. A 3-bit select field in a control register picks what advances the count. The count can be held, or it can step once per system clock. It can also step on one of four enable pulses taken from a shared, free-running 10-bit prescaler, at divide ratios 8, 64, 256 and 1024. The last choice is a transition on an external pin, either falling or rising, after the pin is synchronized to the system clock. Every prescaler output is a one-cycle enable, so all of the logic runs on the single system clock.

Software reaches four byte-wide registers through a simple write strobe and a combinational read port. These are the count, the clock select, the overflow interrupt enable and the overflow flag. When the count wraps from 255 to 0, the flag is set. The interrupt request is high while the flag, its enable and an external global enable input are all high. The flag is cleared by a one-cycle service acknowledge input, or by writing a one to its bit.

Top module: `tmr8_unit`

## Requirements
- R1: After reset the count, control, enable and flag registers all read 0, and irq is 0.
- R2: Select code 0 holds the count. Select code 1 adds one to the count on every clock.
- R3: Select codes 2, 3, 4 and 5 add one to the count once every 8, 64, 256 and 1024 clocks respectively. All four rates come from one free-running 10-bit prescaler.
- R4: Select code 6 counts falling transitions of ext_pin, and code 7 counts rising transitions, after a two-stage synchronizer. Levels that each last one clock are still counted, one per transition.
- R5: When the count advances from 255 to 0, the overflow flag (bit 1 of address 3) becomes 1.
- R6: The flag is cleared by irq_ack, or by a write to address 3 with bit 1 set. A write with bit 1 clear leaves the flag unchanged. If a wrap falls in the same cycle as a clear, the flag ends up 1.
- R7: irq is 1 exactly while glob_ie, the enable bit (bit 1 of address 2) and the flag are all 1.
- R8: A write to the count (address 0) takes priority over an increment in the same cycle. That increment is lost, and no overflow is flagged for it.
- R9: The register map is: address 0 holds the full 8-bit count, address 1 holds the select field in bits 2:0, and addresses 2 and 3 use bit 1 only. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| ext_pin | input | 1 | External count source, asynchronous |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Overflow interrupt service acknowledge |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two collisions can happen in a single cycle. The first is a software write to the count landing on the same edge as an increment. The bench provokes it by starting the counter on the clock source and writing the count on the very next edge, once with the count at 255. It then checks that the written value stands, that the next value is one above it, and that the flag stays clear. The second is a wrap that coincides with a clear of the flag. The bench holds irq_ack high on exactly the edge where the count goes from 255 to 0, and requires the flag to read 1 afterwards.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [2:0] {
    SEL_STOP     = 3'd0,
    SEL_CLK      = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } clk_sel_e;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_MASK  = 2'd2;
  localparam logic [1:0] ADDR_FLAG  = 2'd3;
  localparam int OVF_BIT = 1;
  localparam int N_TAPS  = 4;

  // log2 of the divide ratio for each prescaler tap
  function automatic int tap_log(input int idx);
    case (idx)
      0:       tap_log = 3;
      1:       tap_log = 6;
      2:       tap_log = 8;
      default: tap_log = 10;
    endcase
  endfunction
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [N_TAPS-1:0] tap_pulse
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb pre_d = pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // each tap pulses for one cycle when its low bits are all ones
  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    localparam int L = tap_log(g);
    assign tap_pulse[g] = &pre_q[L-1:0];
  end
endmodule

// File: rtl/tmr8_extsync.sv
module tmr8_extsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              lvl;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    lvl    = sync_q[STAGES-1];
    rise_o = lvl & ~prev_q;
    fall_o = ~lvl & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= lvl;
    end
  end
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_o = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
  import tmr8_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_pin,
  input  logic              glob_ie,
  input  logic              irq_ack,
  output logic              irq
);
  localparam int SEL_W = 3;

  logic [SEL_W-1:0]  ctrl_q, ctrl_d;
  logic              ie_q, ie_d;
  logic              flag_q, flag_d;
  logic [N_TAPS-1:0] taps;
  logic              ext_rise, ext_fall;
  logic              cnt_wr, cnt_tick, cnt_wrap;
  logic [DATA_W-1:0] cnt_q;
  logic              flag_wclr;
  clk_sel_e          sel;

  tmr8_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tap_pulse(taps)
  );

  tmr8_extsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin),
    .rise_o(ext_rise), .fall_o(ext_fall)
  );

  tmr8_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(cnt_wr), .load_val_i(wr_data),
    .tick_i(cnt_tick), .cnt_o(cnt_q), .wrap_o(cnt_wrap)
  );

  always_comb begin
    sel = clk_sel_e'(ctrl_q);
    case (sel)
      SEL_STOP:     cnt_tick = 1'b0;
      SEL_CLK:      cnt_tick = 1'b1;
      SEL_DIV8:     cnt_tick = taps[0];
      SEL_DIV64:    cnt_tick = taps[1];
      SEL_DIV256:   cnt_tick = taps[2];
      SEL_DIV1024:  cnt_tick = taps[3];
      SEL_EXT_FALL: cnt_tick = ext_fall;
      SEL_EXT_RISE: cnt_tick = ext_rise;
      default:      cnt_tick = 1'b0;
    endcase
  end

  always_comb begin
    cnt_wr    = wr_en && (addr == ADDR_COUNT);
    flag_wclr = wr_en && (addr == ADDR_FLAG) && wr_data[OVF_BIT];
    ctrl_d    = ctrl_q;
    ie_d      = ie_q;
    if (wr_en && addr == ADDR_CTRL) ctrl_d = wr_data[SEL_W-1:0];
    if (wr_en && addr == ADDR_MASK) ie_d = wr_data[OVF_BIT];
    // a wrap in the same cycle as a clear leaves the flag set
    if (cnt_wrap)                     flag_d = 1'b1;
    else if (irq_ack || flag_wclr)    flag_d = 1'b0;
    else                              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_COUNT: rd_data = cnt_q;
      ADDR_CTRL:  rd_data[SEL_W-1:0] = ctrl_q;
      ADDR_MASK:  rd_data[OVF_BIT] = ie_q;
      default:    rd_data[OVF_BIT] = flag_q;
    endcase
    irq = glob_ie & ie_q & flag_q;
  end
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sel,
  input logic [7:0] cnt,
  input logic       cnt_wr,
  input logic       cnt_tick,
  input logic [7:0] wr_data,
  input logic       flag,
  input logic       irq_ack,
  input logic       wrap
);
  a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 8'hFF && cnt_tick && !cnt_wr) |=> flag);

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wr_data)));

  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !cnt_wr) |=> $stable(cnt));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == 8'($past(cnt) + 8'd1)));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !wrap) |=> !flag);
endmodule

bind tmr8_unit tmr8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(ctrl_q), .cnt(cnt_q), .cnt_wr(cnt_wr),
  .cnt_tick(cnt_tick), .wr_data(wr_data), .flag(flag_q),
  .irq_ack(irq_ack), .wrap(cnt_wrap)
);

// File: tb/tb_tmr8_unit.sv
module tb_tmr8_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       ext_pin = 1'b0;
  logic       glob_ie = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  tmr8_unit dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ext_pin(ext_pin), .glob_ie(glob_ie),
    .irq_ack(irq_ack), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write happens on the next posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq", irq, 0);
  endtask

  task automatic t_map();
    logic [7:0] v;
    wr(2'd1, 8'hF8); rd(2'd1, v); chk("R9 ctrl reserved bits", v, 8'h00);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R9 enable uses bit 1", v, 8'h02);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R9 flag reads 0", v, 8'h00);
  endtask

  task automatic t_stop_and_clk();
    logic [7:0] v;
    wr(2'd1, 8'h00); wr(2'd0, 8'h37);
    repeat (20) @(negedge clk);
    rd(2'd0, v); chk("R2 stop holds count", v, 8'h37);
    wr(2'd0, 8'h00); wr(2'd1, 8'h01);
    rd(2'd0, v); chk("R2 no step on select edge", v, 0);
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R2 clock source steps each cycle", v, 10);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_div(input logic [2:0] code, input int ratio);
    logic [7:0] v, c;
    int n;
    wr(2'd1, {5'd0, code});
    rd(2'd0, c);
    n = 0;
    do begin @(negedge clk); rd(2'd0, v); n++; end while (v == c && n < 3000);
    c = v; n = 0;
    do begin @(negedge clk); rd(2'd0, v); n++; end while (v == c && n < 3000);
    chk($sformatf("R3 prescaled period code %0d", code), n, ratio);
    chk($sformatf("R3 single step code %0d", code), 8'(v - c), 1);
    wr(2'd1, 8'h00);
  endtask

  task automatic ext_prep(input logic [2:0] code);
    wr(2'd1, 8'h00);
    ext_pin = 1'b0;
    repeat (6) @(negedge clk);
    wr(2'd0, 8'h00);
    wr(2'd1, {5'd0, code});
  endtask

  task automatic pulses(input int n, input int hold);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1'b1; repeat (hold) @(negedge clk);
      ext_pin = 1'b0; repeat (hold) @(negedge clk);
    end
  endtask

  task automatic t_ext();
    logic [7:0] v;
    ext_prep(3'd7);
    pulses(3, 3); ext_pin = 1'b1; repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R4 rising edges counted", v, 4);
    ext_prep(3'd6);
    pulses(3, 3); ext_pin = 1'b1; repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R4 falling edges counted", v, 3);
    ext_pin = 1'b0; repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R4 last falling edge counted", v, 4);
    ext_prep(3'd7);
    pulses(5, 1); repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R4 one-cycle spacing", v, 5);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_overflow_irq();
    logic [7:0] v;
    wr(2'd0, 8'hFE); wr(2'd1, 8'h01);
    @(negedge clk);
    rd(2'd3, v); chk("R5 no flag at 255", v, 0);
    rd(2'd0, v); chk("R5 count at 255", v, 8'hFF);
    @(negedge clk);
    rd(2'd3, v); chk("R5 flag after wrap", v, 8'h02);
    rd(2'd0, v); chk("R5 count wraps to 0", v, 0);
    wr(2'd1, 8'h00);
    glob_ie = 1'b1; #1;
    chk("R7 no irq without enable", irq, 0);
    wr(2'd2, 8'h02); #1;
    chk("R7 irq with all three set", irq, 1);
    glob_ie = 1'b0; #1;
    chk("R7 no irq without global enable", irq, 0);
    glob_ie = 1'b1;
    wr(2'd3, 8'hFD); rd(2'd3, v);
    chk("R6 writing 0 to flag keeps it", v, 8'h02);
    chk("R7 irq still set", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    rd(2'd3, v); chk("R6 acknowledge clears flag", v, 0);
    chk("R7 irq drops after clear", irq, 0);
    wr(2'd0, 8'hFF); wr(2'd1, 8'h01); wr(2'd1, 8'h00);
    rd(2'd3, v); chk("R6 flag set again", v, 8'h02);
    wr(2'd3, 8'h02); rd(2'd3, v); chk("R6 write one clears flag", v, 0);
    wr(2'd2, 8'h00); glob_ie = 1'b0;
  endtask

  task automatic t_collisions();
    logic [7:0] v;
    wr(2'd0, 8'h20); wr(2'd1, 8'h01);
    wr(2'd0, 8'h40);
    rd(2'd0, v); chk("R8 write beats increment", v, 8'h40);
    @(negedge clk);
    rd(2'd0, v); chk("R8 counting resumes", v, 8'h41);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFF); wr(2'd1, 8'h01);
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h00);
    rd(2'd3, v); chk("R8 overwritten wrap not flagged", v, 0);
    rd(2'd0, v); chk("R8 count after overwrite", v, 8'h11);
    wr(2'd0, 8'hFF); wr(2'd1, 8'h01);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    rd(2'd3, v); chk("R6 wrap beats acknowledge", v, 8'h02);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_stop_and_clk();
    t_div(3'd2, 8);
    t_div(3'd3, 64);
    t_div(3'd4, 256);
    t_div(3'd5, 1024);
    t_ext();
    t_overflow_irq();
    t_collisions();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule